// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block gathers sixteen interrupt lines into two chained eight-line priority controllers. Lines 8 to 15 feed the secondary controller. Whenever that controller holds a request it may present, it pulses primary line 2 once, as an edge. A host programs both controllers through a small byte-wide register window. The window holds one command address and one data address per controller. It also holds two trigger-mode registers that choose, line by line, whether a line is edge- or level-sensitive.

The vector output always shows the vector that an interrupt fetch would return at that moment. If the primary controller resolves to line 2, the secondary controller's best line is used instead. When the host takes the interrupt, it returns the vector on the acknowledge port. The block then moves the matching request into service in the right controller, or in both controllers when the vector belongs to the secondary one.

Each controller uses fixed priority: line 0 is the highest and line 7 the lowest. A line that is in service holds off every line of equal or lower priority.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A write to address 4 stores the data ANDed with 8'hF8 as the primary trigger-mode register, and address 4 reads it back. Primary lines 0, 1 and 2 therefore stay edge-sensitive. A bit value of 1 means level-sensitive.
- R2: A write to address 5 stores the data ANDed with 8'hDE as the secondary trigger-mode register, and address 5 reads it back. Lines 8 and 13 therefore stay edge-sensitive.
- R3: On an edge-sensitive line, a 0-to-1 transition sets the request bit, and a later return to 0 leaves the bit set. The request register reads at the command address (0 for primary, 2 for secondary) after a select write of 8'h0A.
- R4: On a level-sensitive line, the request bit follows the line: it is set while the line is high and cleared once the line falls.
- R5: Line activity is ignored while a controller is not initialized. Initialization is a command write with bit 4 set, bit 0 set and bit 1 clear, followed by three data writes. The first data write supplies the vector base in bits 7:3. The third data write must have bit 0 set, and its bit 1 enables auto end-of-interrupt.
- R6: When the secondary controller has a request it may present and no raise is outstanding, the block marks the secondary as raised and pulses primary line 2. This sets primary request bit 2.
- R7: The vector output is the base of the resolved controller plus the resolved line. The primary resolves first; if it resolves to line 2, the secondary is used. A controller with no eligible line yields line 7 of that controller.
- R8: Acknowledging a vector whose bits 7:3 equal the secondary base puts bit vector[2:0] in service in the secondary controller and bit 2 in service in the primary controller.
- R9: Acknowledging any other vector puts bit vector[2:0] in service in the primary controller and clears that request bit if its line is low. The service register reads at the command address after a select write of 8'h0B.
- R10: Fixed priority applies: lower line numbers win, and a line in service blocks all lines of equal or lower priority. The mask register is written at the data address after initialization; a set bit blocks the line.
- R11: A command write with bit 5 set and bits 4 and 3 clear ends an interrupt. With bit 6 clear it clears the highest-priority bit in service. With bit 6 set it clears the bit named by bits 2:0.
- R12: With auto end-of-interrupt enabled, acknowledging a vector sets no service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | Interrupt lines; bits 15:8 feed the secondary controller |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: 0/1 primary command/data, 2/3 secondary command/data, 4/5 trigger modes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the register selected by addr |
| vec_out | output | 8 | Vector an interrupt fetch would return now |
| int_out | output | 1 | Primary controller has raised an interrupt to the host |
| ack_valid | input | 1 | One-cycle acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |

## Verification
The assertions assume three things about the inputs. A line change lasts at least one clock cycle. An acknowledge carries a vector that the block is presenting. No acknowledge lands in the same cycle as a write to the primary command address. The directed stimulus follows all three rules. It holds every line change for two or more cycles and acknowledges only vectors that it has first read from the vector output. It issues acknowledges and register writes in separate task calls, so the two never overlap.

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter logic [7:0] PRI_LEVEL_OK = 8'hF8,
  parameter logic [7:0] SEC_LEVEL_OK = 8'hDE,
  parameter int         CASC_LINE    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [7:0]  vec_out,
  output logic        int_out,
  input  logic        ack_valid,
  input  logic [7:0]  ack_vector
);

  localparam logic [2:0] CASC = 3'(CASC_LINE);

  logic [7:0] irr [2];
  logic [7:0] isr [2];
  logic [7:0] imr [2];
  logic [7:0] elc [2];
  logic [7:0] line [2];
  logic [7:0] prv [2];
  logic [7:0] irr_n [2];
  logic [7:0] isr_n [2];
  logic [4:0] base [2];
  logic [2:0] step [2];
  logic [2:0] acc_pin [2];
  logic [3:0] pk [2];
  logic [1:0] ready, aeoi, raised, rd_isr, raise, acc_en, cmd_wr, dat_wr, elc_wr, icw1;
  logic       casc;
  logic       ack_slv;

  function automatic logic [3:0] pick(input logic [7:0] req, input logic [7:0] msk,
                                      input logic [7:0] svc);
    logic stop;
    pick = 4'b0;
    stop = 1'b0;
    for (int p = 0; p < 8; p++) begin
      if (!stop) begin
        if (svc[p]) stop = 1'b1;
        else if (req[p] && !msk[p]) begin
          pick = {1'b1, 3'(p)};
          stop = 1'b1;
        end
      end
    end
  endfunction

  function automatic logic [3:0] top_svc(input logic [7:0] svc);
    top_svc = 4'b0;
    for (int p = 7; p >= 0; p--)
      if (svc[p]) top_svc = {1'b1, 3'(p)};
  endfunction

  assign line[0] = {irq_in[7:3], irq_in[2] | casc, irq_in[1:0]};
  assign line[1] = irq_in[15:8];

  assign ack_slv   = ack_valid && (ack_vector[7:3] == base[1]);
  assign acc_en[0] = ack_valid;
  assign acc_en[1] = ack_slv;
  assign acc_pin[0] = ack_slv ? CASC : ack_vector[2:0];
  assign acc_pin[1] = ack_vector[2:0];

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    assign cmd_wr[c] = wr_en && (addr == 3'(2 * c));
    assign dat_wr[c] = wr_en && (addr == 3'(2 * c + 1));
    assign elc_wr[c] = wr_en && (addr == 3'(4 + c));
    assign icw1[c]   = cmd_wr[c] && wdata[4];
    assign pk[c]     = pick(irr[c], imr[c], isr[c]);
    assign raise[c]  = ready[c] && !raised[c] && pk[c][3] && !acc_en[c] && !icw1[c];

    always_comb begin
      logic [3:0] hs;
      irr_n[c] = irr[c];
      isr_n[c] = isr[c];
      hs = top_svc(isr[c]);
      if (acc_en[c]) begin
        if (!line[c][acc_pin[c]]) irr_n[c][acc_pin[c]] = 1'b0;
        if (!aeoi[c]) isr_n[c][acc_pin[c]] = 1'b1;
      end
      if (ready[c]) begin
        for (int i = 0; i < 8; i++) begin
          if (elc[c][i]) irr_n[c][i] = line[c][i];
          else if (line[c][i] && !prv[c][i]) irr_n[c][i] = 1'b1;
        end
      end
      if (cmd_wr[c] && ready[c] && !wdata[4] && !wdata[3] && wdata[5]) begin
        if (wdata[6]) isr_n[c][wdata[2:0]] = 1'b0;
        else if (hs[3]) isr_n[c][hs[2:0]] = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr[c] <= '0; isr[c] <= '0; imr[c] <= '0; elc[c] <= '0; prv[c] <= '0;
        base[c] <= '0; step[c] <= '0; ready[c] <= 1'b0; aeoi[c] <= 1'b0;
        raised[c] <= 1'b0; rd_isr[c] <= 1'b0;
      end else begin
        prv[c] <= line[c];
        if (elc_wr[c]) elc[c] <= wdata & ((c == 0) ? PRI_LEVEL_OK : SEC_LEVEL_OK);
        if (icw1[c]) begin
          ready[c]  <= 1'b0;
          irr[c]    <= '0;
          isr[c]    <= '0;
          imr[c]    <= '0;
          aeoi[c]   <= 1'b0;
          raised[c] <= 1'b0;
          rd_isr[c] <= 1'b0;
          step[c]   <= (wdata[0] && !wdata[1]) ? 3'd2 : 3'd0;
        end else begin
          irr[c] <= irr_n[c];
          isr[c] <= isr_n[c];
          if (acc_en[c]) raised[c] <= 1'b0;
          else if (raise[c]) raised[c] <= 1'b1;
          if (cmd_wr[c] && ready[c] && wdata[3] && wdata[1]) rd_isr[c] <= wdata[0];
          if (dat_wr[c]) begin
            case (step[c])
              3'd2: begin base[c] <= wdata[7:3]; step[c] <= 3'd3; end
              3'd3: step[c] <= 3'd4;
              3'd4: if (wdata[0]) begin
                ready[c] <= 1'b1;
                aeoi[c]  <= wdata[1];
                step[c]  <= 3'd0;
              end
              default: imr[c] <= wdata;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) casc <= 1'b0;
    else        casc <= raise[1];
  end

  always_comb begin
    if (pk[0][3] && pk[0][2:0] == CASC)
      vec_out = {base[1], pk[1][3] ? pk[1][2:0] : 3'd7};
    else
      vec_out = {base[0], pk[0][3] ? pk[0][2:0] : 3'd7};
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = rd_isr[0] ? isr[0] : irr[0];
      3'd1:    rdata = imr[0];
      3'd2:    rdata = rd_isr[1] ? isr[1] : irr[1];
      3'd3:    rdata = imr[1];
      3'd4:    rdata = elc[0];
      3'd5:    rdata = elc[1];
      default: rdata = 8'h00;
    endcase
  end

  assign int_out = raised[0];

  // R6
  cascade_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc |-> raised[1]);

  // R5
  idle_pri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready[0] |-> irr[0] == 8'h00);

  // R5
  idle_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready[1] |-> irr[1] == 8'h00);

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready[0] && $past(ready[0])) |-> ((irr[0] ^ $past(line[0])) & $past(elc[0])) == 8'h00);

  // R8
  slave_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slv && ready[0] && !aeoi[0] && !(wr_en && addr == 3'd0)) |=> isr[0][CASC_LINE]);

  // R12
  auto_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_slv && aeoi[0] && ready[0] && isr[0] == 8'h00 && !wr_en)
      |=> isr[0] == 8'h00);

endmodule

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, vec_out;
  logic        int_out;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_vector = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  dual_irq_ctrl i_dual_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .vec_out(vec_out), .int_out(int_out),
    .ack_valid(ack_valid), .ack_vector(ack_vector));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(req, rdata, exp);
  endtask

  task automatic ack(input logic [7:0] v);
    @(negedge clk);
    ack_valid = 1'b1; ack_vector = v;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_in[n] = 1'b1;
    tick(2);
    irq_in[n] = 1'b0;
    tick(2);
  endtask

  task automatic init_pri(input logic [7:0] icw4);
    wr(3'd0, 8'h11); wr(3'd1, 8'h20); wr(3'd1, 8'h04); wr(3'd1, icw4);
  endtask

  task automatic t_reset;
    rd_check("reset R3", 3'd0, 8'h00);
    rd_check("reset R10", 3'd1, 8'h00);
    check("reset R7", vec_out, 8'h07);
    check("reset int", {7'b0, int_out}, 8'h00);
  endtask

  task automatic t_init_gate;
    pulse(4); pulse(9);
    init_pri(8'h01);
    wr(3'd2, 8'h11); wr(3'd3, 8'h28); wr(3'd3, 8'h02); wr(3'd3, 8'h01);
    rd_check("R5 primary ignored", 3'd0, 8'h00);
    rd_check("R5 secondary ignored", 3'd2, 8'h00);
  endtask

  task automatic t_modes;
    wr(3'd4, 8'hFF); rd_check("R1", 3'd4, 8'hF8);
    wr(3'd5, 8'hFF); rd_check("R2", 3'd5, 8'hDE);
    wr(3'd4, 8'h08); wr(3'd5, 8'h00);
    rd_check("R1 rewrite", 3'd4, 8'h08);
  endtask

  task automatic t_edge_level;
    @(negedge clk); irq_in[4] = 1'b1; tick(2);
    rd_check("R3 rise", 3'd0, 8'h10);
    irq_in[4] = 1'b0; tick(2);
    rd_check("R3 fall keeps", 3'd0, 8'h10);
    check("R7 primary vector", vec_out, 8'h24);
    check("int raised", {7'b0, int_out}, 8'h01);
    irq_in[3] = 1'b1; tick(2);
    rd_check("R4 high", 3'd0, 8'h18);
    check("R10 lower wins", vec_out, 8'h23);
    irq_in[3] = 1'b0; tick(2);
    rd_check("R4 low clears", 3'd0, 8'h10);
  endtask

  task automatic t_ack_eoi;
    ack(8'h24);
    wr(3'd0, 8'h0B); rd_check("R9 service", 3'd0, 8'h10);
    wr(3'd0, 8'h0A); rd_check("R9 request cleared", 3'd0, 8'h00);
    check("R7 spurious primary", vec_out, 8'h27);
    pulse(6);
    check("R10 blocked", vec_out, 8'h27);
    pulse(1);
    check("R10 higher passes", vec_out, 8'h21);
    wr(3'd0, 8'h0B);
    wr(3'd0, 8'h20); rd_check("R11 nonspecific", 3'd0, 8'h00);
    ack(8'h21); rd_check("R9 service 1", 3'd0, 8'h02);
    check("R10 blocks 6", vec_out, 8'h27);
    wr(3'd0, 8'h61); rd_check("R11 specific", 3'd0, 8'h00);
    check("R7 next", vec_out, 8'h26);
    ack(8'h26); wr(3'd0, 8'h20);
    rd_check("R11 drained", 3'd0, 8'h00);
  endtask

  task automatic t_cascade;
    pulse(10); tick(3);
    wr(3'd0, 8'h0A); rd_check("R6 cascade request", 3'd0, 8'h04);
    check("R7 secondary vector", vec_out, 8'h2A);
    ack(8'h2A);
    wr(3'd0, 8'h0B); rd_check("R8 primary line 2", 3'd0, 8'h04);
    wr(3'd2, 8'h0B); rd_check("R8 secondary", 3'd2, 8'h04);
    check("R7 after slave ack", vec_out, 8'h27);
    wr(3'd2, 8'h20); wr(3'd0, 8'h20);
    rd_check("R11 secondary clear", 3'd2, 8'h00);
    rd_check("R11 primary clear", 3'd0, 8'h00);
    pulse(11); tick(3);
    wr(3'd3, 8'hFF);
    check("R7 spurious secondary", vec_out, 8'h2F);
    wr(3'd3, 8'h00);
    check("R7 unmasked", vec_out, 8'h2B);
    ack(8'h2B);
    wr(3'd2, 8'h20); wr(3'd0, 8'h20);
    rd_check("R8 cleanup", 3'd2, 8'h00);
  endtask

  task automatic t_auto_eoi;
    init_pri(8'h03);
    pulse(5);
    check("R12 vector", vec_out, 8'h25);
    ack(8'h25);
    wr(3'd0, 8'h0B); rd_check("R12 no service", 3'd0, 8'h00);
    wr(3'd0, 8'h0A); rd_check("R12 request cleared", 3'd0, 8'h00);
    check("R12 idle vector", vec_out, 8'h27);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_init_gate();
    t_modes();
    t_edge_level();
    t_ack_eoi();
    t_cascade();
    t_auto_eoi();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule